// File: doc/BRIEF.md
# Adaptive Interrupt Coalescing Controller

This block sits between the per-frame event pulses of a receive engine and the single interrupt line to the host. It holds interrupts back and reports frames in batches. An interrupt is raised when either of two limits is reached first. The first limit is the number of frames that have gathered since the last interrupt. The second limit is the time, counted in microsecond ticks, since the oldest unreported frame arrived. The raised line stays high until the host acknowledges it. Frames that arrive in the meantime are counted toward the next interrupt.

The controller can also choose its mode from the measured traffic rate. It counts frames over fixed windows of 64 microsecond ticks. When a window holds more frames than a programmable threshold, traffic is classed as heavy and coalescing applies. Otherwise it is classed as light, and every frame raises an interrupt at once. Interrupt generation can be switched off for polled operation. Frames are still counted while it is off, and the host can read that count on a port.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, `irq_out` is 0 and `pend_count` is 0.
- R2: In coalescing mode, `irq_out` rises on the clock edge after `pend_count` reaches `cfg_max_frames`.
- R3: In coalescing mode, each `us_tick` pulse advances an age timer while `pend_count` is non-zero. `irq_out` rises on the clock edge after the age reaches `cfg_max_delay_us`.
- R4: The age timer does not run while no frame is pending. Ticks received on an idle ring are never credited to a later frame.
- R5: When `irq_out` is raised, the frame counter and the age timer are cleared. A frame that arrives on that same edge counts as 1.
- R6: Once raised, `irq_out` stays high until `irq_ack` is sampled high, and it drops on that edge. Frames that arrive while it is high accumulate in `pend_count`. If they already meet a limit, `irq_out` rises again on the edge after the drop.
- R7: A `cfg_max_frames` of 0 or 1, or a `cfg_max_delay_us` of 0, selects immediate mode. In immediate mode, any pending frame raises `irq_out` on the next edge.
- R8: While `cfg_irq_en` is 0, `irq_out` never rises and `pend_count` keeps counting frames. After `cfg_irq_en` is set, any limit already met raises `irq_out`.
- R9: With `cfg_adapt_en` set, a light traffic class selects immediate mode. A heavy class selects coalescing with the configured limits.
- R10: Traffic is classed heavy when the frames in a window of 64 `us_tick` pulses, counted from reset, exceed `cfg_heavy_thresh`. The class changes only on the tick that closes a window. It is light after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_evt | input | 1 | One-cycle pulse per received frame; may be high every cycle |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| cfg_max_frames | input | 8 | Frame-count limit |
| cfg_max_delay_us | input | 10 | Age limit in microsecond ticks |
| cfg_heavy_thresh | input | 8 | Frames per window above which traffic is heavy |
| cfg_adapt_en | input | 1 | Enables switching between modes based on traffic rate |
| cfg_irq_en | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Host acknowledge of the interrupt |
| irq_out | output | 1 | Level interrupt to the host |
| pend_count | output | 8 | Frames counted since the last interrupt was raised (saturating) |

## Verification
Each result has a fixed due cycle. A frame or tick sampled on edge k updates the counter or timer on edge k. A limit that is met raises `irq_out` on edge k+1. An acknowledge sampled on edge k clears the line on edge k. A window boundary on edge k changes the class on edge k, and a pending frame then fires on edge k+1. The bench drives every input on the falling edge and reads the outputs only on a later falling edge, after the edge at which the result is due. For the hold checks it waits several more cycles, so a late or early change is caught either way.

// File: rtl/coal_pkg.sv
// Shared widths for the interrupt coalescing controller.
// Assumes nothing beyond the defaults fitting in the chosen widths.
package coal_pkg;
    parameter int FRAME_W  = 8;   // frame counter / limit width
    parameter int DELAY_W  = 10;  // age timer / limit width
    parameter int RATE_W   = 8;   // per-window frame counter width
    parameter int WIN_US   = 64;  // rate window length in us ticks
endpackage

// File: rtl/coal_rate_meter.sv
// Measures traffic rate: counts frames over a fixed window of WIN_US
// microsecond ticks and classes traffic as heavy when the count exceeds
// the threshold. Assumes frame_evt can be high every cycle; the count saturates.
module coal_rate_meter #(
    parameter int WIN_US = 64,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_evt,
    input  logic              us_tick,
    input  logic [RATE_W-1:0] thresh,
    output logic              heavy
);
    localparam int WIN_W = (WIN_US > 1) ? $clog2(WIN_US) : 1;
    localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WIN_US - 1);
    localparam logic [RATE_W-1:0] RATE_MAX = '1;

    logic [WIN_W-1:0]  win_pos;
    logic [RATE_W-1:0] win_cnt;
    logic [RATE_W-1:0] cnt_next;
    logic              boundary;

    // window closes on the tick that completes WIN_US ticks
    always_comb begin
        boundary = us_tick && (win_pos == WIN_LAST);
        cnt_next = (frame_evt && win_cnt != RATE_MAX) ? win_cnt + 1'b1 : win_cnt;
    end

    // track position within the current window
    always_ff @(posedge clk) begin
        if (!rst_n)          win_pos <= '0;
        else if (boundary)   win_pos <= '0;
        else if (us_tick)    win_pos <= win_pos + 1'b1;
    end

    // count frames in the window and update the class at its end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
            heavy   <= 1'b0;
        end else if (boundary) begin
            win_cnt <= '0;
            heavy   <= (cnt_next > thresh);
        end else begin
            win_cnt <= cnt_next;
        end
    end

    AST_CLASS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(heavy)) else $error("class changed mid-window"); // R10
endmodule

// File: rtl/coal_trigger.sv
// Counts pending frames and the age of the oldest one, and decides when an
// interrupt is due. Assumes the caller raises the line on the cycle fire is high.
module coal_trigger #(
    parameter int FRAME_W = 8,
    parameter int DELAY_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_evt,
    input  logic               us_tick,
    input  logic [FRAME_W-1:0] max_frames,
    input  logic [DELAY_W-1:0] max_delay,
    input  logic               force_immediate,
    input  logic               irq_en,
    input  logic               irq_busy,
    output logic               fire,
    output logic [FRAME_W-1:0] pend
);
    localparam logic [FRAME_W-1:0] PEND_MAX = '1;
    localparam logic [DELAY_W-1:0] AGE_MAX  = '1;

    logic [DELAY_W-1:0] age;
    logic               immediate;
    logic               limit_hit;

    // pick the mode and evaluate the limits against registered state
    always_comb begin
        immediate = force_immediate || (max_frames <= FRAME_W'(1)) || (max_delay == '0);
        limit_hit = immediate || (pend >= max_frames) || (age >= max_delay);
        fire      = irq_en && !irq_busy && (pend != '0) && limit_hit;
    end

    // pending frame counter, restarts on fire
    always_ff @(posedge clk) begin
        if (!rst_n)                              pend <= '0;
        else if (fire)                           pend <= frame_evt ? FRAME_W'(1) : '0;
        else if (frame_evt && pend != PEND_MAX)  pend <= pend + 1'b1;
    end

    // age timer, runs only while a frame is pending
    always_ff @(posedge clk) begin
        if (!rst_n)                                      age <= '0;
        else if (fire)                                   age <= '0;
        else if (pend != '0 && us_tick && age != AGE_MAX) age <= age + 1'b1;
    end

    AST_IDLE_NO_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (age == '0)) else $error("timer ran on idle ring"); // R4
    AST_CLEAR_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (age == '0) && (pend <= FRAME_W'(1))) else $error("no clear"); // R5
endmodule

// File: rtl/irq_coalesce.sv
// Top: interrupt coalescing with count and age limits, adaptive mode
// selection from a rate meter, global enable and a level interrupt held
// until acknowledged. Assumes us_tick and frame_evt are one-cycle pulses.
module irq_coalesce
    import coal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_evt,
    input  logic               us_tick,
    input  logic [FRAME_W-1:0] cfg_max_frames,
    input  logic [DELAY_W-1:0] cfg_max_delay_us,
    input  logic [RATE_W-1:0]  cfg_heavy_thresh,
    input  logic               cfg_adapt_en,
    input  logic               cfg_irq_en,
    input  logic               irq_ack,
    output logic               irq_out,
    output logic [FRAME_W-1:0] pend_count
);
    logic heavy;
    logic fire;
    logic light_imm;

    coal_rate_meter #(.WIN_US(WIN_US), .RATE_W(RATE_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .us_tick(us_tick),
        .thresh(cfg_heavy_thresh), .heavy(heavy)
    );

    // light traffic in adaptive mode forces one interrupt per frame
    always_comb light_imm = cfg_adapt_en && !heavy;

    coal_trigger #(.FRAME_W(FRAME_W), .DELAY_W(DELAY_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .us_tick(us_tick),
        .max_frames(cfg_max_frames), .max_delay(cfg_max_delay_us),
        .force_immediate(light_imm), .irq_en(cfg_irq_en), .irq_busy(irq_out),
        .fire(fire), .pend(pend_count)
    );

    // level interrupt: set on fire, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_out <= 1'b0;
        else if (fire)    irq_out <= 1'b1;
        else if (irq_ack) irq_out <= 1'b0;
    end

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !irq_ack) |=> irq_out) else $error("irq dropped"); // R6
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && irq_ack) |=> !irq_out) else $error("ack ignored"); // R6
    AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |=> !$rose(irq_out)) else $error("irq while masked"); // R8
endmodule

// File: tb/irq_coalesce_bench.sv
module irq_coalesce_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_evt = 1'b0;
    logic       us_tick = 1'b0;
    logic [7:0] cfg_max_frames = 8'd4;
    logic [9:0] cfg_max_delay_us = 10'd500;
    logic [7:0] cfg_heavy_thresh = 8'd10;
    logic       cfg_adapt_en = 1'b0;
    logic       cfg_irq_en = 1'b1;
    logic       irq_ack = 1'b0;
    logic       irq_out;
    logic [7:0] pend_count;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_coalesce u_irq_coalesce (
        .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .us_tick(us_tick),
        .cfg_max_frames(cfg_max_frames), .cfg_max_delay_us(cfg_max_delay_us),
        .cfg_heavy_thresh(cfg_heavy_thresh), .cfg_adapt_en(cfg_adapt_en),
        .cfg_irq_en(cfg_irq_en), .irq_ack(irq_ack),
        .irq_out(irq_out), .pend_count(pend_count)
    );

    // {max_frames, frames sent, expected irq, expected pend_count}
    localparam int VEC [8][4] = '{
        '{4, 3, 0, 3}, '{4, 4, 1, 0}, '{4, 6, 1, 2}, '{1, 1, 1, 0},
        '{0, 3, 1, 2}, '{8, 8, 1, 0}, '{2, 1, 0, 1}, '{3, 5, 1, 2}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    task automatic frames(input int n);
        frame_evt = 1'b1;
        cyc(n);
        frame_evt = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1;
            cyc(1);
            us_tick = 1'b0;
            cyc(1);
        end
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        cyc(1);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1 irq after reset", int'(irq_out), 0);
        check("R1 pend after reset", int'(pend_count), 0);

        // count-limit vectors (R2, R5, R6, R7)
        for (int v = 0; v < 8; v++) begin
            do_reset();
            cfg_max_frames = 8'(VEC[v][0]);
            frames(VEC[v][1]);
            cyc(3);
            check("R2 count irq", int'(irq_out), VEC[v][2]);
            check("R5 leftover pend", int'(pend_count), VEC[v][3]);
        end

        // R3 age limit
        do_reset();
        cfg_max_frames = 8'd16; cfg_max_delay_us = 10'd3;
        frames(1);
        ticks(2);
        check("R3 not yet aged", int'(irq_out), 0);
        ticks(1);
        check("R3 aged out", int'(irq_out), 1);

        // R4 idle ticks are not credited
        do_reset();
        ticks(10);
        check("R4 idle no irq", int'(irq_out), 0);
        frames(1);
        cyc(2);
        check("R4 fresh frame not aged", int'(irq_out), 0);

        // R7 zero delay means immediate
        do_reset();
        cfg_max_delay_us = 10'd0;
        frames(1);
        cyc(1);
        check("R7 delay 0 immediate", int'(irq_out), 1);
        cfg_max_delay_us = 10'd500;

        // R6 hold until ack, refire on backlog
        do_reset();
        cfg_max_frames = 8'd2;
        frames(4);
        cyc(10);
        check("R6 held", int'(irq_out), 1);
        check("R6 backlog counted", int'(pend_count), 2);
        ack();
        check("R6 dropped on ack", int'(irq_out), 0);
        cyc(1);
        check("R6 refire", int'(irq_out), 1);
        check("R5 cleared on refire", int'(pend_count), 0);

        // R8 polled operation
        do_reset();
        cfg_max_frames = 8'd4; cfg_irq_en = 1'b0;
        frames(5);
        cyc(3);
        check("R8 masked", int'(irq_out), 0);
        check("R8 still counted", int'(pend_count), 5);
        cfg_irq_en = 1'b1;
        cyc(1);
        check("R8 fires on enable", int'(irq_out), 1);

        // R9/R10 adaptive switching
        do_reset();
        cfg_adapt_en = 1'b1; cfg_max_frames = 8'd8; cfg_max_delay_us = 10'd200;
        cfg_heavy_thresh = 8'd10;
        frames(1);
        cyc(1);
        check("R9 light immediate", int'(irq_out), 1);
        ack();
        cyc(1);
        check("R9 refire none", int'(irq_out), 0);
        cfg_irq_en = 1'b0;
        frames(20);
        ticks(64);
        cfg_irq_en = 1'b1;
        cyc(1);
        check("R10 heavy batch fires", int'(irq_out), 1);
        ack();
        frames(1);
        cyc(3);
        check("R9 heavy coalesces", int'(irq_out), 0);
        ticks(63);
        check("R10 class held mid-window", int'(irq_out), 0);
        ticks(1);
        check("R10 light after boundary", int'(irq_out), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule